// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block is the master side of a four-channel audio serial link. It takes four 24-bit PCM samples per frame and shifts them out on two data lines, together with a bit clock and a frame clock that it generates itself from the system clock. The bit clock is derived by dividing the system clock. All data and frame-clock transitions are aligned to the falling edge of the bit clock, so a receiver can sample on the rising edge.

The mode code is a static configuration input. It selects one of four stereo framings, or one of two packed time-slot framings. In the stereo framings, each data line carries one stereo pair. In the packed framings, all four channels travel on the first data line. A second static input selects the word width. Once per frame the block raises a one-cycle request, and the four samples present on that cycle are captured for the following frame.

The block is configured by tying the mode and width inputs and releasing reset. Changing either input requires a reset.

Top module: `audio_ser_tx`

## Requirements
- R1: While reset is asserted, `bclk_o`, `lrclk_o`, `sd_o` and `sample_req_o` are all 0. The first frame after reset carries all-zero data.
- R2: `bclk_o` is a square wave with a period of 2*DIV_HALF system clocks. `sd_o` and `lrclk_o` change only on the system clock edge where `bclk_o` falls.
- R3: `sample_i` holds channel c in bits [c*24 +: 24], with c0 = pair-0 left, c1 = pair-0 right, c2 = pair-1 left and c3 = pair-1 right. The width code (`width_i`) is 00 = 24 bits, 01 = 20 bits and 10 = 16 bits. A word is the top W bits of the sample, sent MSB first. Every slot bit outside the word is 0.
- R4: Mode 000 (I2S) uses a 64-bit frame made of two 32-bit halves. `lrclk_o` is low in the left half and high in the right half. Line 0 carries c0/c1 and line 1 carries c2/c3. The MSB falls on bit 1 of each half.
- R5: Mode 011 (left-justified) is like R4, except that `lrclk_o` is high in the left half and the MSB falls on bit 0 of each half.
- R6: Mode 001 (right-justified) uses the same frame clock as R5. The MSB falls on bit 32-W of each half, so the LSB occupies bit 31.
- R7: Mode 010 (DSP) uses a 64-bit frame in which `lrclk_o` is high only during bit 0. On each line, the left word starts at bit 1 and the right word follows directly after the left LSB.
- R8: Mode 101 (packed 128) uses a 128-bit frame in which `lrclk_o` is high only during bit 0. Line 0 carries four 32-bit slots in the order c0, c2, c1, c3, each word MSB first at the start of its slot. Line 1 stays 0.
- R9: Mode 100 (packed 256) uses a 256-bit frame with eight 32-bit slots, and `lrclk_o` is high only during bit 0. Slots 0, 1, 4 and 5 carry c0, c2, c1 and c3. The other slots, and line 1, stay 0.
- R10: `sample_req_o` is a one-cycle pulse, issued once per frame when the last bit of the frame starts. The `sample_i` value present on that cycle is sent in the next frame.
- R11: Mode codes 110 and 111, and width code 11, are invalid. With an invalid code, `sd_o` and `lrclk_o` stay 0, `sample_req_o` never pulses, and `bclk_o` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Framing mode code, static |
| width_i | input | 2 | Word width code, static |
| sample_i | input | 96 | Four 24-bit samples, channel c at [c*24 +: 24] |
| sample_req_o | output | 1 | One-cycle pulse; `sample_i` is captured on this cycle |
| bclk_o | output | 1 | Bit clock |
| lrclk_o | output | 1 | Frame clock |
| sd_o | output | 2 | Serial data lines 0 and 1 |

## Verification
The assertions assume that `mode_i` and `width_i` change only while reset is held. They also assume that `sample_i` is valid on the cycle of each request pulse. The bench sets a new configuration only with reset asserted. It presents fresh random samples, or a directed pattern, at the instant the request is seen, and holds them until the next request. Every mode is run against every valid width with a bench model of slot positions. The invalid mode and width codes are run separately to show that the outputs stay quiet.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;
  localparam logic [2:0] MODE_I2S   = 3'd0;
  localparam logic [2:0] MODE_RJ    = 3'd1;
  localparam logic [2:0] MODE_DSP   = 3'd2;
  localparam logic [2:0] MODE_LJ    = 3'd3;
  localparam logic [2:0] MODE_PK256 = 3'd4;
  localparam logic [2:0] MODE_PK128 = 3'd5;

  localparam int N_CH    = 4;
  localparam int N_LANES = 2;

  function automatic logic cfg_ok(input logic [2:0] m, input logic [1:0] wc);
    return (m <= MODE_PK128) && (wc != 2'b11);
  endfunction

  function automatic int word_bits(input logic [1:0] wc, input int sample_w);
    return sample_w - 4 * int'(wc);
  endfunction

  function automatic int frame_bits(input logic [2:0] m, input int slot_w);
    case (m)
      MODE_PK256: return 8 * slot_w;
      MODE_PK128: return 4 * slot_w;
      default:    return 2 * slot_w;
    endcase
  endfunction
endpackage

// File: rtl/audio_tx_clkgen.sv
module audio_tx_clkgen #(
  parameter int DIV_HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic bclk_o,
  output logic fall_o
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          tick;

  assign tick   = (cnt_q == CW'(DIV_HALF - 1));
  assign fall_o = tick & bclk_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      bclk_o <= 1'b0;
    end else if (tick) begin
      cnt_q  <= '0;
      bclk_o <= ~bclk_o;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/audio_tx_framer.sv
module audio_tx_framer import audio_tx_pkg::*; #(
  parameter int SLOT_W = 32,
  parameter int POS_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  input  logic [2:0]       mode_i,
  input  logic [1:0]       width_i,
  output logic [POS_W-1:0] pos_nxt_o,
  output logic             req_o
);
  logic [POS_W-1:0] pos_q;
  logic [POS_W-1:0] last;

  assign last      = POS_W'(frame_bits(mode_i, SLOT_W) - 1);
  assign pos_nxt_o = (pos_q >= last) ? '0 : pos_q + 1'b1;

  // reset parks on the final position so the first falling edge opens bit 0
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '1;
      req_o <= 1'b0;
    end else begin
      req_o <= fall_i && cfg_ok(mode_i, width_i) && (pos_nxt_o == last);
      if (fall_i) pos_q <= pos_nxt_o;
    end
  end
endmodule

// File: rtl/audio_tx_bitmap.sv
module audio_tx_bitmap import audio_tx_pkg::*; #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int POS_W    = 8
) (
  input  logic [POS_W-1:0]         pos_i,
  input  logic [2:0]               mode_i,
  input  logic [1:0]               width_i,
  input  logic [N_CH*SAMPLE_W-1:0] buf_i,
  output logic [N_LANES-1:0]       sd_o,
  output logic                     lr_o
);
  function automatic logic pick(input logic [N_CH*SAMPLE_W-1:0] b,
                                input int ch, input int off, input int w);
    if (ch < 0 || ch >= N_CH || off < 0 || off >= w) return 1'b0;
    return b[ch*SAMPLE_W + SAMPLE_W - 1 - off];
  endfunction

  always_comb begin
    int p, w, hp, half, slot;
    p    = int'(pos_i);
    w    = word_bits(width_i, SAMPLE_W);
    hp   = p % SLOT_W;
    slot = p / SLOT_W;
    half = slot % 2;
    sd_o = '0;
    lr_o = 1'b0;
    if (cfg_ok(mode_i, width_i)) begin
      case (mode_i)
        MODE_I2S: begin
          lr_o = (half != 0);
          for (int l = 0; l < N_LANES; l++) sd_o[l] = pick(buf_i, 2*l + half, hp - 1, w);
        end
        MODE_LJ: begin
          lr_o = (half == 0);
          for (int l = 0; l < N_LANES; l++) sd_o[l] = pick(buf_i, 2*l + half, hp, w);
        end
        MODE_RJ: begin
          lr_o = (half == 0);
          for (int l = 0; l < N_LANES; l++)
            sd_o[l] = pick(buf_i, 2*l + half, hp - (SLOT_W - w), w);
        end
        MODE_DSP: begin
          lr_o = (p == 0);
          for (int l = 0; l < N_LANES; l++)
            sd_o[l] = pick(buf_i, 2*l, p - 1, w) | pick(buf_i, 2*l + 1, p - 1 - w, w);
        end
        MODE_PK128: begin
          lr_o    = (p == 0);
          sd_o[0] = pick(buf_i, slot / 2 + 2 * (slot % 2), hp, w);
        end
        MODE_PK256: begin
          lr_o = (p == 0);
          if ((slot % 4) < 2) sd_o[0] = pick(buf_i, slot / 4 + 2 * (slot % 4), hp, w);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/audio_ser_tx.sv
module audio_ser_tx import audio_tx_pkg::*; #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int DIV_HALF = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [2:0]               mode_i,
  input  logic [1:0]               width_i,
  input  logic [N_CH*SAMPLE_W-1:0] sample_i,
  output logic                     sample_req_o,
  output logic                     bclk_o,
  output logic                     lrclk_o,
  output logic [N_LANES-1:0]       sd_o
);
  localparam int POS_W = $clog2(8 * SLOT_W);

  logic                     fall;
  logic [POS_W-1:0]         pos_nxt;
  logic [N_CH*SAMPLE_W-1:0] buf_q;
  logic [N_LANES-1:0]       sd_nxt;
  logic                     lr_nxt;

  audio_tx_clkgen #(.DIV_HALF(DIV_HALF)) i_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .bclk_o(bclk_o),
    .fall_o(fall)
  );

  audio_tx_framer #(.SLOT_W(SLOT_W), .POS_W(POS_W)) i_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fall_i   (fall),
    .mode_i   (mode_i),
    .width_i  (width_i),
    .pos_nxt_o(pos_nxt),
    .req_o    (sample_req_o)
  );

  audio_tx_bitmap #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W), .POS_W(POS_W)) i_bitmap (
    .pos_i  (pos_nxt),
    .mode_i (mode_i),
    .width_i(width_i),
    .buf_i  (buf_q),
    .sd_o   (sd_nxt),
    .lr_o   (lr_nxt)
  );

  // capture lands before the falling edge that opens the next frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q   <= '0;
      sd_o    <= '0;
      lrclk_o <= 1'b0;
    end else begin
      if (sample_req_o) buf_q <= sample_i;
      if (fall) begin
        sd_o    <= sd_nxt;
        lrclk_o <= lr_nxt;
      end
    end
  end
endmodule

// File: rtl/audio_ser_tx_chk.sv
module audio_ser_tx_chk #(
  parameter int N_LANES = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [2:0]         mode_i,
  input logic [1:0]         width_i,
  input logic               sample_req_o,
  input logic               bclk_o,
  input logic               lrclk_o,
  input logic [N_LANES-1:0] sd_o
);
  logic bad_cfg;
  logic packed_mode;
  assign bad_cfg     = (mode_i > 3'd5) || (width_i == 2'b11);
  assign packed_mode = (mode_i == 3'd4) || (mode_i == 3'd5);

  p_sd_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sd_o) |-> $fell(bclk_o));

  p_lr_on_fall_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(lrclk_o) |-> $fell(bclk_o));

  p_req_single_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_req_o |=> !sample_req_o);

  p_req_at_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_req_o |-> $fell(bclk_o));

  // R8 and R9: second line idle in packed framings
  p_line1_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (packed_mode && !bad_cfg) |-> (sd_o[1] == 1'b0));

  p_invalid_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cfg |-> (sd_o == '0 && !lrclk_o && !sample_req_o));
endmodule

bind audio_ser_tx audio_ser_tx_chk #(.N_LANES(2)) i_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .width_i     (width_i),
  .sample_req_o(sample_req_o),
  .bclk_o      (bclk_o),
  .lrclk_o     (lrclk_o),
  .sd_o        (sd_o)
);

// File: tb/test_audio_ser_tx.sv
module test_audio_ser_tx;
  localparam int SW = 24;
  localparam int DH = 2;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [2:0]    mode = 3'd0;
  logic [1:0]    wcode = 2'd0;
  logic [4*SW-1:0] smp = '0;
  logic          sample_req_o, bclk_o, lrclk_o;
  logic [1:0]    sd_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_ser_tx i_audio_ser_tx (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode), .width_i(wcode),
    .sample_i(smp), .sample_req_o(sample_req_o), .bclk_o(bclk_o),
    .lrclk_o(lrclk_o), .sd_o(sd_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int flen_of(input int m);
    if (m == 4) return 256;
    if (m == 5) return 128;
    return 64;
  endfunction

  // word bit 'off' of channel ch, zero outside the word (R3)
  function automatic logic wbit(input logic [4*SW-1:0] s, input int ch, input int off, input int w);
    if (off < 0 || off >= w) return 1'b0;
    return s[ch*SW + SW - 1 - off];
  endfunction

  // expected {lrclk, sd1, sd0} at frame bit p
  function automatic logic [2:0] exp_out(input int m, input int w, input int p, input logic [4*SW-1:0] s);
    int half, hp, st, slot;
    logic lr, d0, d1;
    half = p / 32; hp = p % 32; slot = p / 32;
    lr = 0; d0 = 0; d1 = 0;
    if (m <= 3 && m != 2) begin
      st = (m == 0) ? 1 : (m == 3) ? 0 : 32 - w;   // R4 / R5 / R6
      lr = (m == 0) ? (half == 1) : (half == 0);
      d0 = wbit(s, half, hp - st, w);
      d1 = wbit(s, 2 + half, hp - st, w);
    end else if (m == 2) begin                      // R7
      lr = (p == 0);
      d0 = (p <= w) ? wbit(s, 0, p - 1, w) : wbit(s, 1, p - 1 - w, w);
      d1 = (p <= w) ? wbit(s, 2, p - 1, w) : wbit(s, 3, p - 1 - w, w);
    end else begin                                  // R8 / R9
      lr = (p == 0);
      case (slot)
        0: d0 = wbit(s, 0, hp, w);
        1: d0 = wbit(s, 2, hp, w);
        2: d0 = (m == 5) ? wbit(s, 1, hp, w) : 1'b0;
        3: d0 = (m == 5) ? wbit(s, 3, hp, w) : 1'b0;
        4: d0 = wbit(s, 1, hp, w);
        5: d0 = wbit(s, 3, hp, w);
        default: d0 = 1'b0;
      endcase
    end
    return {lr, d1, d0};
  endfunction

  task automatic do_reset(input int m, input int wc);
    rst_ni = 1'b0; mode = 3'(m); wcode = 2'(wc); smp = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(bclk_o == 0 && sd_o == 0 && lrclk_o == 0 && sample_req_o == 0, "R1",
        "reset outputs", int'({sample_req_o, bclk_o, lrclk_o, sd_o}), 0);
    rst_ni = 1'b1;
  endtask

  task automatic run_cfg(input int m, input int wc, input int nframes, input string tag);
    int fl, w, rises, reqs, pos_err, per_err, last_rise, cyc, ferr, fa, fe, fp;
    logic prev_b;
    logic [4*SW-1:0] cur, nxt;
    fl = flen_of(m); w = SW - 4 * wc;
    rises = 0; reqs = 0; pos_err = 0; per_err = 0; last_rise = 0; cyc = 0;
    ferr = 0; fa = 0; fe = 0; fp = 0;
    cur = '0; nxt = '0;
    do_reset(m, wc);
    prev_b = 1'b0;
    while (rises < nframes * fl + 1) begin
      @(posedge clk); #1; cyc++;
      if (sample_req_o) begin
        reqs++;
        if (rises == 0 || (rises % fl) != 0) pos_err++;
        for (int c = 0; c < 4; c++)
          nxt[c*SW +: SW] = (reqs == 1) ? SW'(24'h800001 ^ (c << 8)) : SW'($urandom);
        smp = nxt;
      end
      if (bclk_o && !prev_b) begin
        if (rises > 1 && (cyc - last_rise) != 2 * DH) per_err++;
        last_rise = cyc;
        if (rises > 0) begin
          int p, fr;
          logic [2:0] e, a;
          p = (rises - 1) % fl; fr = (rises - 1) / fl;
          if (p == 0 && fr > 0) cur = nxt;   // R10: latched on request, used next frame
          e = exp_out(m, w, p, cur);
          a = {lrclk_o, sd_o};
          if (a !== e && ferr == 0) begin fa = int'(a); fe = int'(e); fp = p; end
          if (a !== e) ferr++;
          if (p == fl - 1) begin
            chk(ferr == 0, tag, $sformatf("mode %0d wc %0d frame %0d bit %0d {lr,sd1,sd0} (R3)", m, wc, fr, fp), fa, fe);
            ferr = 0;
          end
        end
        rises++;
      end
      prev_b = bclk_o;
    end
    chk(per_err == 0, "R2", $sformatf("bclk period errors mode %0d", m), per_err, 0);
    chk(reqs == nframes, "R10", $sformatf("request count mode %0d", m), reqs, nframes);
    chk(pos_err == 0, "R10", $sformatf("request placement mode %0d", m), pos_err, 0);
  endtask

  task automatic run_bad(input int m, input int wc);
    int noisy, rises;
    logic prev_b;
    noisy = 0; rises = 0;
    do_reset(m, wc);
    prev_b = 1'b0;
    repeat (600) begin
      @(posedge clk); #1;
      if (sd_o != 0 || lrclk_o || sample_req_o) noisy++;
      if (bclk_o && !prev_b) rises++;
      prev_b = bclk_o;
      smp = {4{SW'($urandom)}};
    end
    chk(noisy == 0, "R11", $sformatf("quiet outputs mode %0d wc %0d", m, wc), noisy, 0);
    chk(rises > 100, "R11", "bclk runs when invalid", rises, 150);
  endtask

  initial begin
    string tags[6];
    void'($urandom(32'h1a2b3c));
    tags[0] = "R4"; tags[1] = "R6"; tags[2] = "R7";
    tags[3] = "R5"; tags[4] = "R9"; tags[5] = "R8";
    for (int m = 0; m < 6; m++)
      for (int wc = 0; wc < 3; wc++)
        run_cfg(m, wc, (m == 4) ? 2 : 3, tags[m]);
    run_bad(6, 0);
    run_bad(7, 1);
    run_bad(0, 3);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule